// File: doc/BRIEF.md
# Banked GPIO Controller with Level and Latched Interrupts

This block is a memory-mapped controller for 32 general-purpose pins. The pins are grouped into four banks of eight. Each bank owns a 64-byte register window, and the two top address bits choose the bank. Inside a window, software can set each pin's direction and output value and can read back the synchronized pin levels. It can also inspect and clear interrupt status, enable or disable interrupts for each pin, and switch a pin into a latched ("sticky") interrupt mode.

Every pin input passes through a two-flop synchronizer before any other logic sees it. A pin in the default mode reports its synchronized level as its raw status. A sticky pin records a rising level and keeps it until software clears it. The block drives a single interrupt line, which is the OR of the enabled status bits of all four banks. Access is through a plain synchronous register bus: a write takes effect at the next clock edge, and read data is a combinational function of the address and the current state.

Top module: `pinbank_gpio`

## Requirements
- R1: Pin n is bit (n mod 8) of bank (n div 8). Address bits [7:6] select the bank and bits [5:0] the register offset, so pin 10 appears as bit 2 at addresses 0x40–0x7F.
- R2: After reset:
  - every mask bit and every direction bit reads 1;
  - the output, sticky and status registers read 0;
  - `pin_oe`, `pin_out` and `irq` are all 0.
- R3: Offset 0x10 is the direction register, where 1 means input and 0 means output, and `pin_oe` is its inverse. Offset 0x14 is the output register and drives `pin_out`. Both are read/write and take effect one clock after the write.
- R4: Offset 0x18 is read-only and returns the pin levels after two synchronizing flops. A pin change is visible on the second clock edge after it, and not on the first.
- R5: Offset 0x08 reads the mask. Writing 1s to 0x08 sets those mask bits, which disables those pins' interrupts. Offset 0x0C is write-only: writing 1s clears those mask bits, and a read of 0x0C returns 0.
- R6: Offset 0x04 reads the raw status. For a pin that is not sticky, the status bit equals the synchronized level delayed by one clock, that is, 3 edges after the pin changes.
- R7: Offset 0x20 reads the sticky setting, and writing 1s to it sets those bits. For a sticky pin:
  - the status bit sets on a rising synchronized level;
  - it holds until a 1 is written to that bit at 0x04;
  - a rise in the same cycle as that clear leaves the bit set.
- R8: Offset 0x00 reads the raw status ANDed with the inverted mask. Writes to 0x00 have no effect.
- R9: `irq` is 1 exactly when some bank has a status bit set whose mask bit is 0.
- R10: Unmapped offsets read 0. `bus_rdata[15:8]` always reads 0. Bits 15:8 of `bus_wdata` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: bank in [7:6], offset in [5:0] |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data; only bits 7:0 are used |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable to the pads, 1 = driving |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: four banks of eight pins, a 6-bit window offset, a 16-bit data bus and two synchronizer stages. With these values an 8-bit random address covers every bank and every mapped and unmapped offset, and random 16-bit write data exercises the ignored upper byte. The two-stage synchronizer gives short latencies that the directed cases check to the exact edge, including a sticky rise that lands in the same cycle as a clear. Random phases are cut by periodic resets, so that sticky bits, which software cannot clear, do not fill up.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  // Register offsets inside one bank window; software decodes these.
  typedef enum logic [5:0] {
    OFF_MSTAT  = 6'h00,  // enabled status, read-only
    OFF_STAT   = 6'h04,  // raw status, write 1 to clear
    OFF_MSET   = 6'h08,  // mask, write 1 to set
    OFF_MCLR   = 6'h0C,  // write 1 to clear mask, write-only
    OFF_DIR    = 6'h10,  // 1 = input
    OFF_OUT    = 6'h14,  // output data
    OFF_IN     = 6'h18,  // synchronized levels, read-only
    OFF_STICKY = 6'h20   // latch mode, write 1 to set
  } reg_off_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pinbank_section.sv
module pinbank_section
  import pinbank_pkg::*;
#(
  parameter int W     = 8,
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [OFF_W-1:0] off,
  input  logic [W-1:0]     wd,
  input  logic [W-1:0]     lvl,
  output logic [W-1:0]     rd,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     sticky_q,
  output logic [W-1:0]     stat_q,
  output logic             any_irq
);

  function automatic logic hit(input logic [OFF_W-1:0] o, input reg_off_e c);
    return o == OFF_W'(c);
  endfunction

  // Status update: latched pins keep or gain, level pins follow the input.
  function automatic logic [W-1:0] status_next(
    input logic [W-1:0] sticky,
    input logic [W-1:0] cur,
    input logic [W-1:0] level,
    input logic [W-1:0] rise,
    input logic [W-1:0] clr
  );
    return (sticky & ((cur & ~clr) | rise)) | (~sticky & level);
  endfunction

  logic [W-1:0] lvl_d;
  logic [W-1:0] rise_ev;
  logic [W-1:0] clr_bits, mset_bits, mclr_bits, stset_bits;
  logic         wr_dir, wr_out;

  assign rise_ev    = lvl & ~lvl_d;
  assign clr_bits   = (sel_we && hit(off, OFF_STAT))   ? wd : '0;
  assign mset_bits  = (sel_we && hit(off, OFF_MSET))   ? wd : '0;
  assign mclr_bits  = (sel_we && hit(off, OFF_MCLR))   ? wd : '0;
  assign stset_bits = (sel_we && hit(off, OFF_STICKY)) ? wd : '0;
  assign wr_dir     = sel_we && hit(off, OFF_DIR);
  assign wr_out     = sel_we && hit(off, OFF_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d    <= '0;
      stat_q   <= '0;
      dir_q    <= '1;
      out_q    <= '0;
      mask_q   <= '1;
      sticky_q <= '0;
    end else begin
      lvl_d    <= lvl;
      stat_q   <= status_next(sticky_q, stat_q, lvl, rise_ev, clr_bits);
      mask_q   <= (mask_q | mset_bits) & ~mclr_bits;
      sticky_q <= sticky_q | stset_bits;
      if (wr_dir) dir_q <= wd;
      if (wr_out) out_q <= wd;
    end
  end

  always_comb begin
    rd = '0;
    if (hit(off, OFF_MSTAT))  rd = stat_q & ~mask_q;
    if (hit(off, OFF_STAT))   rd = stat_q;
    if (hit(off, OFF_MSET))   rd = mask_q;
    if (hit(off, OFF_DIR))    rd = dir_q;
    if (hit(off, OFF_OUT))    rd = out_q;
    if (hit(off, OFF_IN))     rd = lvl;
    if (hit(off, OFF_STICKY)) rd = sticky_q;
  end

  assign any_irq = |(stat_q & ~mask_q);

endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int BANKS       = 4,
  parameter int BANK_W      = 8,
  parameter int WIN_BITS    = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NPINS  = BANKS * BANK_W,
  localparam int SEL_W  = $clog2(BANKS),
  localparam int ADDR_W = WIN_BITS + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  localparam int PAD = DATA_W - BANK_W;

  logic [SEL_W-1:0]    bank_sel;
  logic [WIN_BITS-1:0] off;
  logic [BANK_W-1:0]   wd_lo;
  logic [PAD-1:0]      unused_wdata_hi;
  logic [NPINS-1:0]    lvl_sync;

  assign bank_sel        = bus_addr[ADDR_W-1 -: SEL_W];
  assign off             = bus_addr[WIN_BITS-1:0];
  assign wd_lo           = bus_wdata[BANK_W-1:0];
  assign unused_wdata_hi = bus_wdata[DATA_W-1:BANK_W];

  // Named write events, visible to the checker.
  logic wr_stat_ev, wr_mset_ev, wr_mclr_ev, wr_dir_ev;
  assign wr_stat_ev = bus_we && (off == WIN_BITS'(OFF_STAT));
  assign wr_mset_ev = bus_we && (off == WIN_BITS'(OFF_MSET));
  assign wr_mclr_ev = bus_we && (off == WIN_BITS'(OFF_MCLR));
  assign wr_dir_ev  = bus_we && (off == WIN_BITS'(OFF_DIR));

  pinbank_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .d   (pin_in),
    .q   (lvl_sync)
  );

  logic [BANK_W-1:0] rd_bank [BANKS];
  logic [BANKS-1:0]  bank_irq;
  logic [NPINS-1:0]  stat_all, mask_all, sticky_all, dir_all;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    pinbank_section #(.W(BANK_W), .OFF_W(WIN_BITS)) u_sec (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_we  (bus_we && (bank_sel == SEL_W'(b))),
      .off     (off),
      .wd      (wd_lo),
      .lvl     (lvl_sync[b*BANK_W +: BANK_W]),
      .rd      (rd_bank[b]),
      .dir_q   (dir_all[b*BANK_W +: BANK_W]),
      .out_q   (pin_out[b*BANK_W +: BANK_W]),
      .mask_q  (mask_all[b*BANK_W +: BANK_W]),
      .sticky_q(sticky_all[b*BANK_W +: BANK_W]),
      .stat_q  (stat_all[b*BANK_W +: BANK_W]),
      .any_irq (bank_irq[b])
    );
  end

  assign pin_oe    = ~dir_all;
  assign bus_rdata = {{PAD{1'b0}}, rd_bank[bank_sel]};
  assign irq       = |bank_irq;

endmodule

// File: rtl/pinbank_gpio_chk.sv
module pinbank_gpio_chk
  import pinbank_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int BANK_W   = 8,
  parameter int WIN_BITS = 6,
  parameter int DATA_W   = 16,
  localparam int NPINS  = BANKS * BANK_W,
  localparam int SEL_W  = $clog2(BANKS),
  localparam int ADDR_W = WIN_BITS + SEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BANK_W-1:0] wd_lo,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  stat_all,
  input logic [NPINS-1:0]  mask_all,
  input logic [NPINS-1:0]  sticky_all,
  input logic              wr_stat_ev,
  input logic              wr_mset_ev,
  input logic              wr_mclr_ev,
  input logic              wr_dir_ev
);

  logic [SEL_W-1:0] bank;
  logic [NPINS-1:0] lane, lane_sel, clr_lane, held;

  assign bank     = bus_addr[ADDR_W-1 -: SEL_W];
  assign lane     = NPINS'(wd_lo) << (BANK_W * bank);
  assign lane_sel = NPINS'({BANK_W{1'b1}}) << (BANK_W * bank);
  assign clr_lane = wr_stat_ev ? lane : '0;
  assign held     = sticky_all & stat_all & ~clr_lane;

  p_rdata_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:BANK_W] == '0);

  p_wronly_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[WIN_BITS-1:0] == WIN_BITS'(OFF_MCLR)) |-> bus_rdata == '0);

  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset_ev |=> (mask_all & $past(lane)) == $past(lane));

  p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr_ev |=> (mask_all & $past(lane)) == '0);

  p_dir_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_ev |=> (pin_oe & $past(lane_sel)) == (~$past(lane) & $past(lane_sel)));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_all != '1));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_all == '0) |-> !irq);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_all & $past(held)) == $past(held));

endmodule

bind pinbank_gpio pinbank_gpio_chk #(
  .BANKS(BANKS), .BANK_W(BANK_W), .WIN_BITS(WIN_BITS), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .wd_lo     (wd_lo),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .stat_all  (stat_all),
  .mask_all  (mask_all),
  .sticky_all(sticky_all),
  .wr_stat_ev(wr_stat_ev),
  .wr_mset_ev(wr_mset_ev),
  .wr_mclr_ev(wr_mclr_ev),
  .wr_dir_ev (wr_dir_ev)
);

// File: tb/sim_pinbank_gpio.sv
module sim_pinbank_gpio;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_gpio u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Reference model, written from the requirements.
  logic [31:0] m_s1, m_s2, m_prev, m_stat, m_mask, m_dir, m_out, m_sticky;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0;
      m_mask <= '1; m_dir <= '1; m_out <= '0; m_sticky <= '0;
    end else begin
      logic [31:0] ln, nm, nst;
      ln = 32'(bus_wdata[7:0]) << (8 * bus_addr[7:6]);
      nm = ~(32'hFF << (8 * bus_addr[7:6]));
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      for (int i = 0; i < 32; i++) begin
        if (!m_sticky[i]) nst[i] = m_s2[i];
        else if (m_s2[i] && !m_prev[i]) nst[i] = 1'b1;
        else if (bus_we && bus_addr[5:0] == 6'h04 && ln[i]) nst[i] = 1'b0;
        else nst[i] = m_stat[i];
      end
      m_stat <= nst;
      if (bus_we) begin
        case (bus_addr[5:0])
          6'h08: m_mask   <= m_mask | ln;
          6'h0C: m_mask   <= m_mask & ~ln;
          6'h10: m_dir    <= (m_dir & nm) | ln;
          6'h14: m_out    <= (m_out & nm) | ln;
          6'h20: m_sticky <= m_sticky | ln;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] mread(input logic [7:0] a);
    logic [31:0] v;
    case (a[5:0])
      6'h00: v = m_stat & ~m_mask;
      6'h04: v = m_stat;
      6'h08: v = m_mask;
      6'h10: v = m_dir;
      6'h14: v = m_out;
      6'h18: v = m_s2;
      6'h20: v = m_sticky;
      default: v = '0;
    endcase
    v = v >> (8 * a[7:6]);
    return {8'h00, v[7:0]};
  endfunction

  function automatic string rtag(input logic [5:0] o);
    case (o)
      6'h00: return "R8";
      6'h04: return "R6";
      6'h08, 6'h0C: return "R5";
      6'h10, 6'h14: return "R3";
      6'h18: return "R4";
      6'h20: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic we, input logic [15:0] d);
    bus_addr = a; bus_we = we; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    bus_we = 1'b0; bus_addr = a; #1;
    chk(tag, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(8'h00, 1'b0, 16'h0);
    cyc(8'h00, 1'b0, 16'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    automatic logic [5:0] offs [11] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10,
                                       6'h14, 6'h18, 6'h20, 6'h1C, 6'h24, 6'h3C};
    automatic int unsigned seed_init = $urandom(32'h5EED_0042);
    @(negedge clk);
    do_reset();

    // R2 reset state in every bank
    for (int b = 0; b < 4; b++) begin
      rdchk("R2 mask", 8'(b*64 + 8'h08), 16'h00FF);
      rdchk("R2 dir", 8'(b*64 + 8'h10), 16'h00FF);
      rdchk("R2 out", 8'(b*64 + 8'h14), 16'h0000);
      rdchk("R2 sticky", 8'(b*64 + 8'h20), 16'h0000);
      rdchk("R2 stat", 8'(b*64 + 8'h04), 16'h0000);
    end
    chk("R2 pin_oe", pin_oe, 32'h0);
    chk("R2 pin_out", pin_out, 32'h0);
    chk("R2 irq", 32'(irq), 32'h0);

    // R1 / R4 / R6: pin 10 is bank 1 bit 2, with exact latencies
    pin_in = 32'h0000_0400;
    cyc(8'h58, 1'b0, 16'h0);
    rdchk("R4 first edge", 8'h58, 16'h0000);
    cyc(8'h58, 1'b0, 16'h0);
    rdchk("R1 R4 pin10 level", 8'h58, 16'h0004);
    rdchk("R6 status not yet", 8'h44, 16'h0000);
    cyc(8'h44, 1'b0, 16'h0);
    rdchk("R6 status follows", 8'h44, 16'h0004);
    rdchk("R1 other bank", 8'h18, 16'h0000);

    // R3 direction and output in bank 2
    cyc(8'h90, 1'b1, 16'h000F);
    cyc(8'h94, 1'b1, 16'h00A5);
    chk("R3 pin_oe", pin_oe, 32'h00F0_0000);
    chk("R3 pin_out", pin_out, 32'h00A5_0000);

    // R10 upper data ignored, unmapped reads zero
    cyc(8'h94, 1'b1, 16'hFF3C);
    rdchk("R10 upper wdata", 8'h94, 16'h003C);
    rdchk("R10 unmapped", 8'h1C, 16'h0000);
    rdchk("R5 write-only reads 0", 8'h0C, 16'h0000);

    // R5 / R8 / R9 level interrupt of pin 10
    rdchk("R8 masked off", 8'h40, 16'h0000);
    chk("R9 irq masked", 32'(irq), 32'h0);
    cyc(8'h4C, 1'b1, 16'h0004);
    rdchk("R8 enabled", 8'h40, 16'h0004);
    chk("R9 irq on", 32'(irq), 32'h1);
    cyc(8'h40, 1'b1, 16'h00FF);
    rdchk("R8 write ignored", 8'h40, 16'h0004);
    cyc(8'h48, 1'b1, 16'h0004);
    rdchk("R5 mask set", 8'h48, 16'h00FF);
    chk("R9 irq off", 32'(irq), 32'h0);

    // R7 sticky latch, hold, clear, rise beats clear
    pin_in = '0;
    do_reset();
    cyc(8'h20, 1'b1, 16'h0001);
    cyc(8'h0C, 1'b1, 16'h0001);
    pin_in = 32'h1;
    repeat (3) cyc(8'h04, 1'b0, 16'h0);
    rdchk("R7 latched", 8'h04, 16'h0001);
    chk("R7 irq", 32'(irq), 32'h1);
    pin_in = '0;
    repeat (4) cyc(8'h04, 1'b0, 16'h0);
    rdchk("R7 held", 8'h04, 16'h0001);
    cyc(8'h04, 1'b1, 16'h0001);
    rdchk("R7 cleared", 8'h04, 16'h0000);
    chk("R7 irq cleared", 32'(irq), 32'h0);
    pin_in = 32'h1;
    cyc(8'h04, 1'b0, 16'h0);
    cyc(8'h04, 1'b0, 16'h0);
    cyc(8'h04, 1'b1, 16'h0001);
    rdchk("R7 rise beats clear", 8'h04, 16'h0001);

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [15:0] d;
      logic        we;
      if (i % 1000 == 0) do_reset();
      if ($urandom % 4 == 0) pin_in = $urandom;
      a  = {2'($urandom), offs[$urandom % 11]};
      we = 1'($urandom);
      d  = 16'($urandom);
      if (a[5:0] == 6'h20) d = d & 16'($urandom) & 16'($urandom) & 16'($urandom);
      cyc(a, we, d);
      chk("R3 pin_out rnd", pin_out, m_out);
      chk("R3 pin_oe rnd", pin_oe, ~m_dir);
      chk("R9 irq rnd", 32'(irq), 32'(|(m_stat & ~m_mask)));
      #1;
      chk({rtag(a[5:0]), " read rnd"}, 32'(bus_rdata), 32'(mread(a)));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog (all R) act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule